// File: doc/BRIEF.md
# Timed DAC Update Sequencer

The block stores a small table of timed updates for a pair of DAC channels and plays it back after a start. Each entry holds a 9-bit trigger time, a channel select and a 14-bit DAC code. Once started, an internal timer counts from zero at half the clock rate. Whenever the timer reaches the time of the current entry, the block drives that entry's code onto the shared DAC data bus. It then pulses the clock line of the selected channel and moves on to the next entry.

A run ends at an entry whose time is zero, or after the last entry has fired and the entry index wraps back to zero. In continuous mode the block restarts from entry 0 with the timer cleared instead of stopping. While idle, the block can hold the DACs in low-power mode. Channel 0 drives the odd-numbered front-end inputs and channel 1 drives the even-numbered ones.

A run is started by a configuration write or by an external pretrigger pulse, and the pretrigger path can be disabled. The table and the configuration are accessed over a simple word-addressed register bus.

Top module: `dac_seq_player`

## Requirements
- R1: A write to offsets 32..63 stores the entry at index offset-32: time from bits 28..20, channel from bit 16, code from bits 13..0. A read of those offsets returns the same fields in the same positions, with every other bit 0.
- R2: Offsets 0..31 hold the configuration. Bit 0 is continuous mode, bit 1 is sleep-while-idle and bit 2 is pretrigger enable. A read returns these three bits, bit 3 as 0 and bit 4 as the running status. After reset the read value is 0x4.
- R3: A run starts when the block is idle and either a configuration write has bit 3 set or `pretrig_start` is high with pretrigger enable set. Start requests made while running are ignored, and `pretrig_start` has no effect while pretrigger enable is 0.
- R4: In the cycle after the start is accepted the timer is 0. The timer then advances by one every two clock cycles and wraps from 511 to 0. An entry with time T first makes its channel clock high 2*T+2 cycles after the start cycle.
- R5: A match occurs when the current entry's nonzero time equals the timer, in the first of the two cycles holding that timer value. `dac_data` shows the entry's code from the next cycle on. In the cycle after that, `dac_clk[ch]` is high for exactly one cycle. `dac_clk[0]` serves channel 0 (odd front-end inputs) and `dac_clk[1]` serves channel 1 (even inputs). At most one clock bit is high at a time.
- R6: Entries are used strictly in index order, one per match. An entry whose time has already passed waits for the timer to wrap round to it.
- R7: An entry with time 0 ends the run in the cycle it is reached, without any DAC update. Firing entry 31 also ends the run.
- R8: With continuous mode set, an end of run restarts playback at entry 0 with the timer at 0 instead of stopping. Clearing continuous mode during a run makes the next end stop the run.
- R9: `dac_sleep` is 1 when the block is idle and sleep-while-idle is set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word offset: bit 5 selects the table, bits 4..0 the entry |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pretrig_start | input | 1 | External start pulse |
| dac_data | output | 14 | Shared DAC code bus |
| dac_clk | output | 2 | Per-channel DAC load clock |
| dac_sleep | output | 1 | DAC low-power request |

## Verification
The two functions that can fall in the same cycle are the firing of the last table entry and the end-of-run decision that follows the index wrap. When continuous mode is set, this also includes the restart that clears the timer. The bench fills all 32 entries with consecutive times so that entry 31 fires in the same cycle as the wrap. It runs this in continuous mode for several loops and then clears continuous mode mid-run. A behavioural model predicts data, clock and sleep for every cycle, and the bench compares them against the design. The bench also checks that the last code still reaches the bus, that its clock pulse still follows, and that the next loop starts from timer 0.

// File: rtl/dac_seq_player.sv
module dac_seq_player #(
  parameter int ENTRIES = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [$clog2(ENTRIES):0]   bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic                       pretrig_start,
  output logic [13:0]                dac_data,
  output logic [1:0]                 dac_clk,
  output logic                       dac_sleep
);
  localparam int AW   = $clog2(ENTRIES);
  localparam int TW   = 9;
  localparam int DW   = 14;
  localparam int TPOS = 20;
  localparam int CPOS = 16;

  logic [TW-1:0] t_mem [ENTRIES];
  logic          c_mem [ENTRIES];
  logic [DW-1:0] v_mem [ENTRIES];

  logic          cont_q, sleep_q, pten_q;
  logic          run_q, phase_q, pend_q, pend_ch_q;
  logic [TW-1:0] timer_q;
  logic [AW-1:0] ptr_q;
  logic [DW-1:0] data_q;
  logic [1:0]    clk_q;

  wire [AW-1:0] idx    = bus_addr[AW-1:0];
  wire          cfg_wr = bus_wr & ~bus_addr[AW];
  wire          tab_wr = bus_wr &  bus_addr[AW];
  wire          start  = ~run_q & ((cfg_wr & bus_wdata[3]) | (pretrig_start & pten_q));
  wire [TW-1:0] cur_t  = t_mem[ptr_q];
  wire          probe  = run_q & ~phase_q;
  wire          zero_e = probe & (cur_t == '0);
  wire          hit    = probe & (cur_t != '0) & (cur_t == timer_q);
  wire          last   = ptr_q == AW'(ENTRIES - 1);
  wire          fin    = zero_e | (hit & last);

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[31:29], bus_wdata[19:17], bus_wdata[15:14]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        t_mem[i] <= '0;
        c_mem[i] <= 1'b0;
        v_mem[i] <= '0;
      end
    end else if (tab_wr) begin
      t_mem[idx] <= bus_wdata[TPOS +: TW];
      c_mem[idx] <= bus_wdata[CPOS];
      v_mem[idx] <= bus_wdata[0 +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q  <= 1'b0;
      sleep_q <= 1'b0;
      pten_q  <= 1'b1;
    end else if (cfg_wr) begin
      cont_q  <= bus_wdata[0];
      sleep_q <= bus_wdata[1];
      pten_q  <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      timer_q <= '0;
      ptr_q   <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      phase_q <= 1'b0;
      timer_q <= '0;
      ptr_q   <= '0;
    end else if (run_q) begin
      if (fin) begin
        run_q   <= cont_q;
        phase_q <= 1'b0;
        timer_q <= '0;
        ptr_q   <= '0;
      end else begin
        phase_q <= ~phase_q;
        if (phase_q) timer_q <= timer_q + 1'b1;
        if (hit) ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      pend_q    <= 1'b0;
      pend_ch_q <= 1'b0;
      clk_q     <= '0;
    end else begin
      pend_q <= hit;
      if (hit) begin
        data_q    <= v_mem[ptr_q];
        pend_ch_q <= c_mem[ptr_q];
      end
      clk_q <= pend_q ? (pend_ch_q ? 2'b10 : 2'b01) : 2'b00;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[AW]) begin
      bus_rdata[TPOS +: TW] = t_mem[idx];
      bus_rdata[CPOS]       = c_mem[idx];
      bus_rdata[0 +: DW]    = v_mem[idx];
    end else begin
      bus_rdata[0] = cont_q;
      bus_rdata[1] = sleep_q;
      bus_rdata[2] = pten_q;
      bus_rdata[4] = run_q;
    end
  end

  assign dac_data  = data_q;
  assign dac_clk   = clk_q;
  assign dac_sleep = sleep_q & ~run_q;
endmodule

// File: rtl/dac_seq_player_chk.sv
module dac_seq_player_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic [8:0]  timer,
  input logic [13:0] dac_data,
  input logic [1:0]  dac_clk,
  input logic        dac_sleep
);
  assert_clk_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dac_clk));

  assert_clk_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_clk != 2'b00) |=> (dac_clk == 2'b00));

  assert_data_settled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_clk != 2'b00) |-> $stable(dac_data));

  assert_awake_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !dac_sleep);

  assert_timer_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (timer == 9'd0));

  assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (timer == $past(timer) || timer == 9'($past(timer) + 9'd1) || timer == 9'd0));
endmodule

bind dac_seq_player dac_seq_player_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .timer(timer_q),
  .dac_data(dac_data), .dac_clk(dac_clk), .dac_sleep(dac_sleep)
);

// File: tb/tb_dac_seq_player.sv
`timescale 1ns/1ps
module tb_dac_seq_player;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pretrig_start = 1'b0;
  logic [13:0] dac_data;
  logic [1:0]  dac_clk;
  logic        dac_sleep;

  always #2 clk = ~clk;

  dac_seq_player dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pretrig_start(pretrig_start),
    .dac_data(dac_data), .dac_clk(dac_clk), .dac_sleep(dac_sleep)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  string tag = "R5";

  // behavioural reference
  int tt[32], tc[32], tv[32];
  int m_run, m_phase, m_timer, m_ptr, m_data, m_clk, m_pend, m_pch;
  int m_cont, m_sleep, m_pten;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (tt[i]) begin tt[i] = 0; tc[i] = 0; tv[i] = 0; end
      m_run = 0; m_phase = 0; m_timer = 0; m_ptr = 0; m_data = 0;
      m_clk = 0; m_pend = 0; m_pch = 0; m_cont = 0; m_sleep = 0; m_pten = 1;
    end else begin
      int fire, stop_now, startq;
      fire = 0; stop_now = 0;
      startq = !m_run && ((bus_wr && !bus_addr[5] && bus_wdata[3]) || (pretrig_start && m_pten));
      m_clk = m_pend ? (m_pch ? 2 : 1) : 0;
      if (m_run && m_phase == 0) begin
        if (tt[m_ptr] == 0) stop_now = 1;
        else if (tt[m_ptr] == m_timer) begin
          fire = 1;
          if (m_ptr == 31) stop_now = 1;
        end
      end
      m_pend = fire;
      if (fire) begin m_data = tv[m_ptr]; m_pch = tc[m_ptr]; end
      if (startq) begin
        m_run = 1; m_phase = 0; m_timer = 0; m_ptr = 0;
      end else if (m_run) begin
        if (stop_now) begin
          m_run = m_cont; m_phase = 0; m_timer = 0; m_ptr = 0;
        end else begin
          if (m_phase == 1) m_timer = (m_timer + 1) % 512;
          m_phase = 1 - m_phase;
          if (fire) m_ptr = m_ptr + 1;
        end
      end
      if (bus_wr && bus_addr[5]) begin
        tt[bus_addr[4:0]] = (bus_wdata >> 20) & 511;
        tc[bus_addr[4:0]] = bus_wdata[16];
        tv[bus_addr[4:0]] = bus_wdata & 16'h3FFF;
      end
      if (bus_wr && !bus_addr[5]) begin
        m_cont = bus_wdata[0]; m_sleep = bus_wdata[1]; m_pten = bus_wdata[2];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int es;
      es = (m_sleep && !m_run) ? 1 : 0;
      checks++;
      if (dac_data !== 14'(m_data) || dac_clk !== 2'(m_clk) || dac_sleep !== 1'(es)) begin
        fails++;
        $display("FAIL %s cycle %0d: data/clk/sleep actual %h/%b/%b expected %h/%b/%b",
                 tag, cycles, dac_data, dac_clk, dac_sleep, 14'(m_data), 2'(m_clk), 1'(es));
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic set_entry(input int i, input int t, input int ch, input int v);
    wr(6'(32 + i), (32'(t) << 20) | (32'(ch) << 16) | 32'(v));
  endtask

  task automatic wait_idle(input int limit);
    for (int k = 0; k < limit; k++) begin
      @(negedge clk);
      bus_addr = 6'd0;
      #0.5;
      if (bus_rdata[4] == 1'b0) break;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd_check("R2", 6'd0, 32'h4);
    check("R9", {31'b0, dac_sleep}, 32'h0);
    // R1 field placement
    wr(6'd37, 32'hFFFF_FFFF);
    rd_check("R1", 6'd37, 32'h1FF1_3FFF);
    set_entry(6, 300, 0, 14'h1555);
    rd_check("R1", 6'd38, (32'd300 << 20) | 32'h1555);
    // R9 sleep while idle, R2 readback
    wr(6'd0, 32'h6);
    rd_check("R2", 6'd0, 32'h6);
    check("R9", {31'b0, dac_sleep}, 32'h1);
    // R4/R5 basic playback
    tag = "R5";
    set_entry(0, 3, 0, 14'h123);
    set_entry(1, 4, 1, 14'h2AB);
    set_entry(2, 10, 0, 14'h3FFF);
    set_entry(3, 0, 1, 14'h777);
    wr(6'd0, 32'hE);
    n = 0;
    while (dac_clk == 2'b00 && n < 100) begin @(negedge clk); n++; end
    check("R4", 32'(n), 32'd8);
    check("R5", {16'b0, 2'b0, dac_data}, 32'h123);
    rd_check("R2", 6'd0, 32'h16);
    check("R9", {31'b0, dac_sleep}, 32'h0);
    // R3 start while running ignored
    tag = "R3";
    wr(6'd0, 32'hE);
    pretrig_start = 1'b1; @(negedge clk); pretrig_start = 1'b0;
    wait_idle(200);
    rd_check("R7", 6'd0, 32'h6);
    check("R5", {16'b0, 2'b0, dac_data}, 32'h3FFF);
    // R6 passed time waits for wrap, started by pretrigger
    tag = "R6";
    set_entry(0, 5, 1, 14'h0AA);
    set_entry(1, 2, 0, 14'h0BB);
    set_entry(2, 0, 0, 14'h0CC);
    @(negedge clk); pretrig_start = 1'b1; @(negedge clk); pretrig_start = 1'b0;
    rd_check("R3", 6'd0, 32'h16);
    wait_idle(1500);
    check("R6", {16'b0, 2'b0, dac_data}, 32'h0BB);
    // R7 zero first entry: no update
    tag = "R7";
    set_entry(0, 0, 1, 14'h111);
    wr(6'd0, 32'hC);
    @(negedge clk);
    rd_check("R7", 6'd0, 32'h4);
    repeat (4) @(negedge clk);
    check("R7", {16'b0, 2'b0, dac_data}, 32'h0BB);
    // R3 pretrigger disabled
    wr(6'd0, 32'h0);
    pretrig_start = 1'b1; @(negedge clk); pretrig_start = 1'b0;
    rd_check("R3", 6'd0, 32'h0);
    // R8 continuous with last-entry wrap
    tag = "R8";
    for (int i = 0; i < 32; i++) set_entry(i, i + 1, i % 2, 14'(i * 37 + 5));
    wr(6'd0, 32'h9);
    repeat (300) @(negedge clk);
    rd_check("R8", 6'd0, 32'h11);
    wr(6'd0, 32'h0);
    wait_idle(200);
    rd_check("R8", 6'd0, 32'h0);
    check("R7", {16'b0, 2'b0, dac_data}, 32'(31 * 37 + 5));
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule